// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software sets it up through a small register port, and it then moves data in units of 1, 2 or 4 bytes between a memory buffer and one peripheral data register. For each unit it does a read on the source bus, then a write on the destination bus. Both buses are simple request/ready master ports, and either one can return an error response. The direction bit chooses which side is the source.

There are two ways to pace a transfer. In paced mode, a RUN bit lets units go only while the peripheral holds its request line high, and the channel answers each finished unit with a one-cycle acknowledge. In free-running mode, hardware flow control is off and a GO bit runs the whole transfer with no handshake.

Software writes a buffer start address and an end address, where end equals start plus the byte count. The start register moves up by the unit size after each unit, so the bytes still to move are always end minus start. The channel reports done, flow-control error and bus error in sticky status bits. It raises an interrupt for any of these that is enabled.

Top module: `dma_channel`

## Requirements
- R1: After reset, every register reads zero, no bus request is active, and `irq` and `hw_ack` are low.
- R2: The register port is a word-index map: 0 block control (bit0 activate, bit1 soft reset), 1 channel activate (bit0), 2 control, 3 start address, 4 end address, 5 device address, 6 status, 7 interrupt enable. Control bits are: bit0 run, bit1 memory-to-device, bit2 memory increment, bit3 device increment, bit4 flow control off, bit5 go, bit6 abort, [22:20] unit size. In free-running mode, each unit is a source read followed by a destination write. The start register then advances by the unit size. When start reaches or passes end, status bit0 (done) is set, and run and go both clear.
- R3: `irq` is high exactly when a status bit is set and the matching interrupt-enable bit is set. With enable bits at zero, done still sets but `irq` stays low.
- R4: A unit size field of 4 moves 4 bytes and 2 moves 2 bytes; any other value moves 1 byte. When the device-increment bit is set, the device address advances by the unit size after each unit; otherwise it stays fixed.
- R5: In paced mode, a unit starts only while `hw_req` is high. After each completed unit, `hw_ack` pulses for one cycle. In free-running mode, `hw_ack` never pulses.
- R6: In paced mode, if `hw_req` falls while a unit is in progress, status bit1 is set, the unit is dropped with start unchanged, and run clears.
- R7: An error response on either bus stops the channel, sets status bit2, and clears run and go. The start register is left pointing at the failing unit.
- R8: Writing ones to the status register clears those bits; zero bits are left as they are.
- R9: When the memory-increment bit is clear, every memory access uses the start address as it was last written, while the start register still counts toward end.
- R10: Writing control with bit6 set stops any unit in progress, starts no new one, and clears run and go. It leaves the status and address registers unchanged.
- R11: No unit starts unless both the block activate and channel activate bits are set. A pending go then proceeds once both are set.
- R12: A hardware status set in the same cycle as a software clear of that bit leaves the bit set.
- R13: Writing block control bit1 returns every register to zero on the next clock, including both activate bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory bus request |
| mem_we | output | 1 | Memory bus write |
| mem_size | output | 2 | Unit size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_addr | output | AW | Memory bus address |
| mem_wdata | output | DW | Memory bus write data |
| mem_rdata | input | DW | Memory bus read data |
| mem_ready | input | 1 | Memory bus accepts/completes the access |
| mem_err | input | 1 | Memory bus error, valid with `mem_ready` |
| dev_req | output | 1 | Device bus request |
| dev_we | output | 1 | Device bus write |
| dev_size | output | 2 | Unit size code, same as `mem_size` |
| dev_addr | output | AW | Device bus address |
| dev_wdata | output | DW | Device bus write data |
| dev_rdata | input | DW | Device bus read data |
| dev_ready | input | 1 | Device bus accepts/completes the access |
| dev_err | input | 1 | Device bus error, valid with `dev_ready` |
| hw_req | input | 1 | Peripheral transfer request |
| hw_ack | output | 1 | One-cycle acknowledge per completed paced unit |
| irq | output | 1 | Channel interrupt |

## Verification
The cycle that finishes the last unit sets the done bit, and a software write to the status register can land in that same cycle. The bench provokes this by waiting until the final destination write is on the device bus. It then drives a status write of one into bit0 so that both events share one clock edge. It judges the outcome by reading the status afterwards: the done bit must still be set. The bench also checks every accepted bus access, in order, against a queue of expected side, direction and address.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic          dev_req,
  output logic          dev_we,
  output logic [1:0]    dev_size,
  output logic [AW-1:0] dev_addr,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata,
  input  logic          dev_ready,
  input  logic          dev_err,
  input  logic          hw_req,
  output logic          hw_ack,
  output logic          irq
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic blk_act, ch_act;
  logic run, to_dev, inc_mem, inc_dev, no_flow, go;
  logic [2:0] usize, sts, ien;
  logic [AW-1:0] start_a, end_a, dev_a, mem_fix;
  logic [DW-1:0] hold;
  logic ack_q;

  logic [AW-1:0] step, next_a;
  logic [1:0] szc;
  logic active, busy, trig, flow_stop, abort_w, srst;
  logic src_ready, src_err, dst_ready, dst_err;
  logic [DW-1:0] src_data;

  assign step   = (usize == 3'd4) ? AW'(4) : (usize == 3'd2) ? AW'(2) : AW'(1);
  assign szc    = (usize == 3'd4) ? 2'd2 : (usize == 3'd2) ? 2'd1 : 2'd0;
  assign next_a = start_a + step;
  assign active = blk_act & ch_act;
  assign busy   = (st != S_IDLE);
  assign abort_w = reg_wr && reg_addr == 3'd2 && reg_wdata[6];
  assign srst    = reg_wr && reg_addr == 3'd0 && reg_wdata[1];
  assign trig   = active && !abort_w && (no_flow ? go : (run && hw_req));
  assign flow_stop = busy && !no_flow && !hw_req;

  assign src_ready = to_dev ? mem_ready : dev_ready;
  assign src_err   = to_dev ? mem_err   : dev_err;
  assign src_data  = to_dev ? mem_rdata : dev_rdata;
  assign dst_ready = to_dev ? dev_ready : mem_ready;
  assign dst_err   = to_dev ? dev_err   : mem_err;

  assign mem_req   = (st == S_RD && to_dev) || (st == S_WR && !to_dev);
  assign dev_req   = (st == S_RD && !to_dev) || (st == S_WR && to_dev);
  assign mem_we    = (st == S_WR);
  assign dev_we    = (st == S_WR);
  assign mem_size  = szc;
  assign dev_size  = szc;
  assign mem_addr  = inc_mem ? start_a : mem_fix;
  assign dev_addr  = dev_a;
  assign mem_wdata = hold;
  assign dev_wdata = hold;
  assign hw_ack    = ack_q;
  assign irq       = |(sts & ien);

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {31'd0, blk_act};
      3'd1: reg_rdata = {31'd0, ch_act};
      3'd2: reg_rdata = {9'd0, usize, 14'd0, go, no_flow, inc_dev, inc_mem, to_dev, run};
      3'd3: reg_rdata = 32'(start_a);
      3'd4: reg_rdata = 32'(end_a);
      3'd5: reg_rdata = 32'(dev_a);
      3'd6: reg_rdata = {29'd0, sts};
      default: reg_rdata = {29'd0, ien};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      st <= S_IDLE;
      blk_act <= 1'b0; ch_act <= 1'b0;
      run <= 1'b0; to_dev <= 1'b0; inc_mem <= 1'b0; inc_dev <= 1'b0;
      no_flow <= 1'b0; go <= 1'b0; usize <= 3'd0;
      start_a <= '0; end_a <= '0; dev_a <= '0; mem_fix <= '0;
      sts <= 3'd0; ien <= 3'd0; hold <= '0; ack_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: blk_act <= reg_wdata[0];
          3'd1: ch_act <= reg_wdata[0];
          3'd2: begin
            run     <= reg_wdata[0] & ~reg_wdata[6];
            to_dev  <= reg_wdata[1];
            inc_mem <= reg_wdata[2];
            inc_dev <= reg_wdata[3];
            no_flow <= reg_wdata[4];
            go      <= reg_wdata[5] & ~reg_wdata[6];
            usize   <= reg_wdata[22:20];
          end
          3'd3: begin start_a <= AW'(reg_wdata); mem_fix <= AW'(reg_wdata); end
          3'd4: end_a <= AW'(reg_wdata);
          3'd5: dev_a <= AW'(reg_wdata);
          3'd6: sts <= sts & ~reg_wdata[2:0];
          default: ien <= reg_wdata[2:0];
        endcase
      end
      case (st)
        S_IDLE: begin
          if (trig) begin
            if (start_a >= end_a) begin
              sts[0] <= 1'b1; run <= 1'b0; go <= 1'b0;
            end else begin
              st <= S_RD;
            end
          end
        end
        S_RD: begin
          if (!active || abort_w) st <= S_IDLE;
          else if (flow_stop) begin
            sts[1] <= 1'b1; run <= 1'b0; st <= S_IDLE;
          end else if (src_ready) begin
            if (src_err) begin
              sts[2] <= 1'b1; run <= 1'b0; go <= 1'b0; st <= S_IDLE;
            end else begin
              hold <= src_data; st <= S_WR;
            end
          end
        end
        default: begin
          if (!active || abort_w) st <= S_IDLE;
          else if (flow_stop) begin
            sts[1] <= 1'b1; run <= 1'b0; st <= S_IDLE;
          end else if (dst_ready) begin
            st <= S_IDLE;
            if (dst_err) begin
              sts[2] <= 1'b1; run <= 1'b0; go <= 1'b0;
            end else begin
              start_a <= next_a;
              if (inc_dev) dev_a <= dev_a + step;
              ack_q <= !no_flow;
              if (next_a >= end_a) begin
                sts[0] <= 1'b1; run <= 1'b0; go <= 1'b0;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       mem_req,
  input logic       dev_req,
  input logic       hw_ack,
  input logic       irq,
  input logic       no_flow,
  input logic       busy,
  input logic       active,
  input logic [2:0] sts,
  input logic [2:0] ien
);
  a_r2_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && dev_req));
  a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |=> !hw_ack);
  a_r5_ack_paced_only: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |-> $past(!no_flow));
  a_r11_inactive_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !active) |=> !busy);
  a_r3_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != 3'd0));
  a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !reg_wr) |=> sts[0]);
endmodule

bind dma_channel dma_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
  .mem_req(mem_req), .dev_req(dev_req), .hw_ack(hw_ack), .irq(irq),
  .no_flow(no_flow), .busy(busy), .active(active), .sts(sts), .ien(ien)
);

// File: tb/dma_channel_test.sv
module dma_channel_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, dev_req, dev_we, hw_ack, irq;
  logic [1:0] mem_size, dev_size;
  logic [31:0] mem_addr, mem_wdata, dev_addr, dev_wdata, mem_rdata, dev_rdata;
  logic mem_ready, mem_err, dev_ready, dev_err;
  logic hw_req = 1'b0;

  logic mem_stall = 1'b0, dev_stall = 1'b0, merr_en = 1'b0;
  logic [31:0] merr_addr = 32'd0;
  logic [31:0] mem [0:63];
  logic [31:0] dev_reg = 32'd0;

  assign mem_ready = !mem_stall;
  assign dev_ready = !dev_stall;
  assign mem_err   = merr_en && mem_addr == merr_addr;
  assign dev_err   = 1'b0;
  assign mem_rdata = mem[mem_addr[7:2]];
  assign dev_rdata = {dev_addr[15:0], 16'hA5A5};

  dma_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
    .dev_req(dev_req), .dev_we(dev_we), .dev_size(dev_size), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ready(dev_ready), .dev_err(dev_err),
    .hw_req(hw_req), .hw_ack(hw_ack), .irq(irq)
  );

  int n_chk = 0, n_err = 0, ack_cnt = 0;
  bit finished = 1'b0;
  logic [33:0] expq [$];

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ready && !mem_err) mem[mem_addr[7:2]] <= mem_wdata;
    if (dev_req && dev_we && dev_ready && !dev_err) dev_reg <= dev_wdata;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (hw_ack) ack_cnt++;
      if ((mem_req && mem_ready) || (dev_req && dev_ready)) begin
        logic [33:0] got;
        got = mem_req ? {1'b0, mem_we, mem_addr} : {1'b1, dev_we, dev_addr};
        n_chk++;
        if (expq.size() == 0) begin
          n_err++;
          $display("FAIL R2 bus access order: actual %h expected none", got);
        end else begin
          logic [33:0] e;
          e = expq.pop_front();
          if (got !== e) begin
            n_err++;
            $display("FAIL R2 bus access order: actual %h expected %h", got, e);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic push(input logic dev, input logic we, input logic [31:0] a);
    expq.push_back({dev, we, a});
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic wait_dev();
    do @(negedge clk); while (!dev_req);
  endtask

  localparam logic [31:0] C_RUN = 32'h1, C_TODEV = 32'h2, C_INCM = 32'h4,
                          C_INCD = 32'h8, C_NOFL = 32'h10, C_GO = 32'h20,
                          C_ABORT = 32'h40;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd6, v); chk("R1 status", v, 0);
    rd(3'd3, v); chk("R1 start", v, 0);
    rd(3'd2, v); chk("R1 control", v, 0);
    chk("R1 outputs", {29'd0, mem_req, dev_req, irq | hw_ack}, 0);

    wr(3'd0, 1); wr(3'd1, 1);

    // R2/R3 free-running mem->dev, 4-byte units
    wr(3'd3, 32'h10); wr(3'd4, 32'h1C); wr(3'd5, 32'h80); wr(3'd7, 1);
    for (int k = 0; k < 3; k++) begin
      push(0, 0, 32'h10 + 4*k); push(1, 1, 32'h80);
    end
    wr(3'd2, C_TODEV | C_INCM | C_NOFL | C_GO | (32'd4 << 20));
    settle();
    chk("R2 last word at device", dev_reg, 32'h1000_0006);
    rd(3'd3, v); chk("R2 start reaches end", v, 32'h1C);
    rd(3'd6, v); chk("R2 done bit", v, 1);
    rd(3'd2, v); chk("R2 go cleared", v & C_GO, 0);
    chk("R3 irq with enable", {31'd0, irq}, 1);
    wr(3'd6, 7);
    rd(3'd6, v); chk("R8 write-one clear", v, 0);
    chk("R3 irq after clear", {31'd0, irq}, 0);
    wr(3'd7, 0);

    // R5/R4 paced dev->mem, 2-byte units, both increments
    wr(3'd3, 32'h40); wr(3'd4, 32'h46); wr(3'd5, 32'h100);
    ack_cnt = 0;
    wr(3'd2, C_RUN | C_INCM | C_INCD | (32'd2 << 20));
    repeat (10) @(negedge clk);
    rd(3'd3, v); chk("R5 no unit without hw_req", v, 32'h40);
    for (int k = 0; k < 3; k++) begin
      push(1, 0, 32'h100 + 2*k); push(0, 1, 32'h40 + 2*k);
    end
    hw_req = 1'b1;
    settle();
    hw_req = 1'b0;
    chk("R5 one ack per unit", ack_cnt, 3);
    rd(3'd3, v); chk("R4 start steps by 2", v, 32'h46);
    rd(3'd5, v); chk("R4 device address steps", v, 32'h106);
    chk("R4 data from device", mem[17], 32'h0104A5A5);
    rd(3'd6, v); chk("R3 done without enable", v, 1);
    chk("R3 irq masked", {31'd0, irq}, 0);
    wr(3'd6, 7);

    // R6 flow-control error
    wr(3'd3, 32'h10); wr(3'd4, 32'h18); wr(3'd5, 32'h80);
    dev_stall = 1'b1; hw_req = 1'b1;
    push(0, 0, 32'h10);
    wr(3'd2, C_RUN | C_TODEV | C_INCM | (32'd4 << 20));
    wait_dev();
    hw_req = 1'b0;
    repeat (3) @(negedge clk);
    dev_stall = 1'b0;
    rd(3'd6, v); chk("R6 flow error bit", v, 2);
    rd(3'd2, v); chk("R6 run cleared", v & C_RUN, 0);
    rd(3'd3, v); chk("R6 start unchanged", v, 32'h10);
    wr(3'd6, 7);

    // R7 bus error on second unit
    merr_en = 1'b1; merr_addr = 32'h14;
    wr(3'd3, 32'h10); wr(3'd4, 32'h1C);
    push(0, 0, 32'h10); push(1, 1, 32'h80); push(0, 0, 32'h14);
    wr(3'd2, C_TODEV | C_INCM | C_NOFL | C_GO | (32'd4 << 20));
    settle();
    merr_en = 1'b0;
    rd(3'd6, v); chk("R7 bus error bit", v, 4);
    rd(3'd3, v); chk("R7 start at failing unit", v, 32'h14);
    rd(3'd2, v); chk("R7 go cleared", v & C_GO, 0);
    wr(3'd6, 7);

    // R10 abort mid-unit
    wr(3'd3, 32'h10); wr(3'd4, 32'h18);
    dev_stall = 1'b1;
    push(0, 0, 32'h10);
    wr(3'd2, C_TODEV | C_INCM | C_NOFL | C_GO | (32'd4 << 20));
    wait_dev();
    wr(3'd2, C_ABORT);
    dev_stall = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 no request after abort", {30'd0, mem_req, dev_req}, 0);
    rd(3'd6, v); chk("R10 status untouched", v, 0);
    rd(3'd3, v); chk("R10 start untouched", v, 32'h10);
    rd(3'd2, v); chk("R10 run/go cleared", v & (C_RUN | C_GO), 0);

    // R9 fixed memory address, 1-byte units
    wr(3'd3, 32'h20); wr(3'd4, 32'h23); wr(3'd5, 32'h90);
    for (int k = 0; k < 3; k++) begin
      push(1, 0, 32'h90); push(0, 1, 32'h20);
    end
    wr(3'd2, C_NOFL | C_GO | (32'd1 << 20));
    settle();
    rd(3'd3, v); chk("R9 start still counts", v, 32'h23);
    chk("R9 data at fixed address", mem[8], 32'h0090A5A5);
    rd(3'd6, v); chk("R9 done", v, 1);
    wr(3'd6, 7);

    // R12 done set and cleared in the same cycle
    wr(3'd3, 32'h10); wr(3'd4, 32'h14); wr(3'd5, 32'h80);
    push(0, 0, 32'h10); push(1, 1, 32'h80);
    wr(3'd2, C_TODEV | C_INCM | C_NOFL | C_GO | (32'd4 << 20));
    wait_dev();
    reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(3'd6, v); chk("R12 set wins over clear", v, 1);
    wr(3'd6, 7);

    // R11 channel inactive holds a pending go
    wr(3'd1, 0);
    wr(3'd3, 32'h10);
    wr(3'd2, C_TODEV | C_INCM | C_NOFL | C_GO | (32'd4 << 20));
    repeat (10) @(negedge clk);
    rd(3'd3, v); chk("R11 no unit while inactive", v, 32'h10);
    push(0, 0, 32'h10); push(1, 1, 32'h80);
    wr(3'd1, 1);
    settle();
    rd(3'd3, v); chk("R11 runs once active", v, 32'h14);

    // R13 soft reset
    wr(3'd7, 5);
    wr(3'd0, 2);
    rd(3'd0, v); chk("R13 block activate cleared", v, 0);
    rd(3'd3, v); chk("R13 start cleared", v, 0);
    rd(3'd5, v); chk("R13 device address cleared", v, 0);
    rd(3'd6, v); chk("R13 status cleared", v, 0);
    rd(3'd7, v); chk("R13 enable cleared", v, 0);

    chk("R2 all expected accesses seen", expq.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule